// File: doc/BRIEF.md
# Load/Store Address Clash Matrix

This block keeps a small table of in-flight memory operations for a multi-issue load/store path. Each slot holds a valid flag, a slice of the address, a unary byte mask, a load flag, a store flag and an age index. For every pair of slots it works out a conservative "may overlap" flag. Each pair is compared once and the result is mirrored into a square matrix. For each slot it also raises a "clear to issue" flag when the slot has no clash with any older valid slot. Issue logic downstream can then send together any set of operations that cannot touch the same bytes.

Only address bits 11 down to 4 are compared, so the check never crosses a page boundary. Bits 3 to 0 are assumed to be already folded into the byte mask. Because the high bits are ignored, two operations on different pages that share the slice are reported as clashing. That false positive costs only a wait. A reported "no clash" is always exact. Every load/store unit owns two slots, one for each cache line that an unaligned access can touch, so the table has twice as many slots as there are units. Slots are filled through a write port per slot and emptied by a release strobe per slot. The matrix reflects a change from the clock edge on which it is captured.

Top module: `ldst_clash_matrix`

## Requirements
- R1: After reset every slot is invalid, every bit of `clash_mtx` is 0 and every bit of `issue_ok` is 0.
- R2: A slot whose `wr_en` bit is high at a rising clock edge holds the new entry and is valid from that edge on. A slot whose `rel` bit is high without its `wr_en` bit becomes invalid at that edge. When both bits are high in the same cycle, the write wins.
- R3: Only address bits [11:4] take part in the comparison. Two entries whose addresses differ only in bits [3:0] or in bits [15:12] are compared as if those bits were equal.
- R4: Two valid entries with equal bits [11:4], where at least one has its store flag set, clash exactly when the bitwise AND of their 16-bit byte masks is nonzero. Bit k of a mask stands for byte k of the 16-byte line.
- R5: Two entries that both have the load flag set and the store flag clear never clash, whatever their masks are.
- R6: An entry with both load and store flags set is atomic. It clashes with every other valid entry that has equal bits [11:4], whatever the masks and the other entry's flags. An entry with neither flag set clashes only through this rule or through a store-flagged partner with overlapping masks.
- R7: An invalid slot has an all-zero row and an all-zero column in the matrix, and the diagonal is always zero. Bit i*N+j of `clash_mtx` is the flag for slots i and j.
- R8: The matrix is symmetric: bit i*N+j always equals bit j*N+i.
- R9: `issue_ok[i]` is 1 exactly when slot i is valid and it clashes with no valid slot that is older. Slot j is older than slot i when its age is smaller, or when the ages are equal and j is less than i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | N | Per-slot write strobe |
| wr_addr | input | N*16 | Per-slot address, slot i at bits [i*16 +: 16] |
| wr_mask | input | N*16 | Per-slot byte mask, slot i at bits [i*16 +: 16] |
| wr_ld | input | N | Per-slot load flag |
| wr_st | input | N | Per-slot store flag |
| wr_age | input | N*3 | Per-slot age index, slot i at bits [i*3 +: 3] |
| rel | input | N | Per-slot release strobe |
| clash_mtx | output | N*N | Pairwise clash flags, pair (i,j) at bit i*N+j |
| issue_ok | output | N | Per-slot clear-to-issue flag |

## Verification
Both results come from combinational logic on the slot registers. A write or release applied before clock edge k therefore shows in `clash_mtx` and `issue_ok` right after edge k and never earlier. The bench drives inputs on the falling edge and updates its behavioural model at that moment, as the next state. It compares every matrix bit and every issue flag with the model on the next falling edge, one register stage later. Reset release goes through a two-flop synchroniser, so the bench waits several cycles before its first write.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  // Access kind as {store, load}
  typedef enum logic [1:0] {
    OP_NONE   = 2'b00,
    OP_LOAD   = 2'b01,
    OP_STORE  = 2'b10,
    OP_ATOMIC = 2'b11
  } op_kind_e;

  // Decide a clash for two valid entries with matching slices
  function automatic logic kind_conflict(op_kind_e a, op_kind_e b, logic bytes_hit);
    logic any_atomic;
    logic any_store;
    any_atomic = (a == OP_ATOMIC) || (b == OP_ATOMIC);
    any_store  = a[1] | b[1];
    return any_atomic | (any_store & bytes_hit);
  endfunction

endpackage

// File: rtl/lsc_entry_slot.sv
module lsc_entry_slot
  import lsc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int MASK_W = 16,
  parameter int AGE_W  = 3,
  parameter int TAG_LO = 4,
  parameter int TAG_HI = 11,
  localparam int TAG_W = TAG_HI - TAG_LO + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rel,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [MASK_W-1:0] wr_mask,
  input  logic              wr_ld,
  input  logic              wr_st,
  input  logic [AGE_W-1:0]  wr_age,
  output logic              valid,
  output logic [TAG_W-1:0]  tag,
  output logic [MASK_W-1:0] mask,
  output op_kind_e          kind,
  output logic [AGE_W-1:0]  age
);

  logic              valid_nx;
  logic [TAG_W-1:0]  tag_nx;
  logic [MASK_W-1:0] mask_nx;
  op_kind_e          kind_nx;
  logic [AGE_W-1:0]  age_nx;
  logic              load_en;

  // Address bits outside the compared slice are deliberately dropped
  logic unused_addr;
  assign unused_addr = ^wr_addr;

  assign load_en = wr_en;

  always_comb begin
    valid_nx = valid;
    if (wr_en) begin
      valid_nx = 1'b1;
    end else if (rel) begin
      valid_nx = 1'b0;
    end
    tag_nx  = wr_addr[TAG_HI:TAG_LO];
    mask_nx = wr_mask;
    kind_nx = op_kind_e'({wr_st, wr_ld});
    age_nx  = wr_age;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
    end else begin
      valid <= valid_nx;
    end
  end

  // Payload has no reset; it is qualified by valid
  always_ff @(posedge clk) begin
    if (load_en) begin
      tag  <= tag_nx;
      mask <= mask_nx;
      kind <= kind_nx;
      age  <= age_nx;
    end
  end

endmodule

// File: rtl/lsc_pair_cmp.sv
module lsc_pair_cmp
  import lsc_pkg::*;
#(
  parameter int TAG_W  = 8,
  parameter int MASK_W = 16
) (
  input  logic              va,
  input  logic              vb,
  input  logic [TAG_W-1:0]  tag_a,
  input  logic [TAG_W-1:0]  tag_b,
  input  logic [MASK_W-1:0] mask_a,
  input  logic [MASK_W-1:0] mask_b,
  input  op_kind_e          kind_a,
  input  op_kind_e          kind_b,
  output logic              hit
);

  logic slice_eq;
  logic bytes_hit;

  always_comb begin
    slice_eq  = (tag_a == tag_b);
    bytes_hit = |(mask_a & mask_b);
    hit       = va & vb & slice_eq & kind_conflict(kind_a, kind_b, bytes_hit);
  end

endmodule

// File: rtl/lsc_issue_gate.sv
module lsc_issue_gate #(
  parameter int N     = 8,
  parameter int AGE_W = 3,
  parameter int SELF  = 0
) (
  input  logic [N-1:0]       valid,
  input  logic [N*AGE_W-1:0] ages,
  input  logic [N-1:0]       clash_row,
  output logic               ok
);

  logic [N-1:0]     older;
  logic [AGE_W-1:0] my_age;

  assign my_age = ages[SELF*AGE_W +: AGE_W];

  always_comb begin
    for (int j = 0; j < N; j++) begin
      logic [AGE_W-1:0] a_j;
      a_j = ages[j*AGE_W +: AGE_W];
      older[j] = valid[j] && (j != SELF) &&
                 ((a_j < my_age) || ((a_j == my_age) && (j < SELF)));
    end
    ok = valid[SELF] && ((older & clash_row) == '0);
  end

endmodule

// File: rtl/ldst_clash_matrix.sv
module ldst_clash_matrix
  import lsc_pkg::*;
#(
  parameter int UNITS  = 4,
  parameter int ADDR_W = 16,
  parameter int MASK_W = 16,
  parameter int TAG_LO = 4,
  parameter int TAG_HI = 11,
  localparam int N      = 2 * UNITS,
  localparam int AGE_W  = $clog2(N),
  localparam int TAG_W  = TAG_HI - TAG_LO + 1,
  localparam int NPAIR  = N * (N - 1) / 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        wr_en,
  input  logic [N*ADDR_W-1:0] wr_addr,
  input  logic [N*MASK_W-1:0] wr_mask,
  input  logic [N-1:0]        wr_ld,
  input  logic [N-1:0]        wr_st,
  input  logic [N*AGE_W-1:0]  wr_age,
  input  logic [N-1:0]        rel,
  output logic [N*N-1:0]      clash_mtx,
  output logic [N-1:0]        issue_ok
);

  // Reset: asserted asynchronously, released through two flops
  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [N-1:0]        ent_valid;
  logic [TAG_W-1:0]    ent_tag  [N];
  logic [MASK_W-1:0]   ent_mask [N];
  op_kind_e            ent_kind [N];
  logic [N*AGE_W-1:0]  ent_ages;
  logic [NPAIR-1:0]    pair_hit;

  for (genvar i = 0; i < N; i++) begin : g_slot
    lsc_entry_slot #(
      .ADDR_W (ADDR_W),
      .MASK_W (MASK_W),
      .AGE_W  (AGE_W),
      .TAG_LO (TAG_LO),
      .TAG_HI (TAG_HI)
    ) u_slot (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr_en   (wr_en[i]),
      .rel     (rel[i]),
      .wr_addr (wr_addr[i*ADDR_W +: ADDR_W]),
      .wr_mask (wr_mask[i*MASK_W +: MASK_W]),
      .wr_ld   (wr_ld[i]),
      .wr_st   (wr_st[i]),
      .wr_age  (wr_age[i*AGE_W +: AGE_W]),
      .valid   (ent_valid[i]),
      .tag     (ent_tag[i]),
      .mask    (ent_mask[i]),
      .kind    (ent_kind[i]),
      .age     (ent_ages[i*AGE_W +: AGE_W])
    );
  end

  // One comparator per unordered pair (upper triangle only)
  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = i + 1; j < N; j++) begin : g_col
      localparam int K = i * N - (i * (i + 1)) / 2 + (j - i - 1);
      lsc_pair_cmp #(
        .TAG_W  (TAG_W),
        .MASK_W (MASK_W)
      ) u_cmp (
        .va     (ent_valid[i]),
        .vb     (ent_valid[j]),
        .tag_a  (ent_tag[i]),
        .tag_b  (ent_tag[j]),
        .mask_a (ent_mask[i]),
        .mask_b (ent_mask[j]),
        .kind_a (ent_kind[i]),
        .kind_b (ent_kind[j]),
        .hit    (pair_hit[K])
      );
    end
  end

  // Mirror into the square matrix
  for (genvar i = 0; i < N; i++) begin : g_mi
    for (genvar j = 0; j < N; j++) begin : g_mj
      if (i == j) begin : g_diag
        assign clash_mtx[i*N+j] = 1'b0;
      end else if (j > i) begin : g_up
        localparam int KU = i * N - (i * (i + 1)) / 2 + (j - i - 1);
        assign clash_mtx[i*N+j] = pair_hit[KU];
      end else begin : g_lo
        localparam int KL = j * N - (j * (j + 1)) / 2 + (i - j - 1);
        assign clash_mtx[i*N+j] = pair_hit[KL];
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_issue
    lsc_issue_gate #(
      .N     (N),
      .AGE_W (AGE_W),
      .SELF  (i)
    ) u_gate (
      .valid     (ent_valid),
      .ages      (ent_ages),
      .clash_row (clash_mtx[i*N +: N]),
      .ok        (issue_ok[i])
    );
  end

endmodule

// File: rtl/lsc_clash_chk.sv
module lsc_clash_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N-1:0]   ent_valid,
  input logic [N-1:0]   wr_en,
  input logic [N-1:0]   rel,
  input logic [N*N-1:0] clash_mtx,
  input logic [N-1:0]   issue_ok
);

  for (genvar i = 0; i < N; i++) begin : g_e
    // R7
    diag_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clash_mtx[i*N+i] == 1'b0);
    // R7
    idle_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ent_valid[i] |-> (clash_mtx[i*N +: N] == '0));
    // R9
    issue_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_ok[i] |-> ent_valid[i]);
    // R2
    alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[i] |=> ent_valid[i]);
    // R2
    free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rel[i] && !wr_en[i]) |=> !ent_valid[i]);
    for (genvar j = i + 1; j < N; j++) begin : g_p
      // R8
      mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clash_mtx[i*N+j] == clash_mtx[j*N+i]);
    end
  end

endmodule

bind ldst_clash_matrix lsc_clash_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .ent_valid (ent_valid),
  .wr_en     (wr_en),
  .rel       (rel),
  .clash_mtx (clash_mtx),
  .issue_ok  (issue_ok)
);

// File: tb/ldst_clash_matrix_bench.sv
`timescale 1ns/1ps
module ldst_clash_matrix_bench;

  localparam int N = 8;
  localparam int AW = 16;
  localparam int MW = 16;
  localparam int GW = 3;

  logic clk;
  logic rst_n;
  logic [N-1:0]    wr_en, wr_ld, wr_st, rel;
  logic [N*AW-1:0] wr_addr;
  logic [N*MW-1:0] wr_mask;
  logic [N*GW-1:0] wr_age;
  logic [N*N-1:0]  clash_mtx;
  logic [N-1:0]    issue_ok;

  ldst_clash_matrix u_ldst_clash_matrix (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_mask(wr_mask), .wr_ld(wr_ld), .wr_st(wr_st), .wr_age(wr_age),
    .rel(rel), .clash_mtx(clash_mtx), .issue_ok(issue_ok)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Stimulus for the coming edge
  bit          d_wr [N];
  bit          d_rel[N];
  bit [15:0]   d_addr[N];
  bit [15:0]   d_mask[N];
  bit          d_ld [N];
  bit          d_st [N];
  int          d_age[N];

  // Behavioural model
  bit          m_v  [N];
  bit [15:0]   m_addr[N];
  bit [15:0]   m_mask[N];
  bit          m_ld [N];
  bit          m_st [N];
  int          m_age[N];

  function automatic bit m_clash(int a, int b);
    if (a == b || !m_v[a] || !m_v[b]) return 0;
    if (m_addr[a][11:4] != m_addr[b][11:4]) return 0;
    if ((m_ld[a] && m_st[a]) || (m_ld[b] && m_st[b])) return 1;
    if (!m_st[a] && !m_st[b]) return 0;
    return (m_mask[a] & m_mask[b]) != 16'h0;
  endfunction

  function automatic bit m_issue(int i);
    if (!m_v[i]) return 0;
    for (int j = 0; j < N; j++) begin
      if (j != i && m_v[j] && (m_age[j] < m_age[i] || (m_age[j] == m_age[i] && j < i))
          && m_clash(i, j)) return 0;
    end
    return 1;
  endfunction

  task automatic check(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  task automatic clear_drive();
    for (int i = 0; i < N; i++) begin
      d_wr[i] = 0; d_rel[i] = 0;
    end
  endtask

  task automatic put(int s, bit [15:0] a, bit [15:0] m, bit ld, bit st, int age);
    d_wr[s] = 1; d_addr[s] = a; d_mask[s] = m; d_ld[s] = ld; d_st[s] = st; d_age[s] = age;
  endtask

  // Drive at a falling edge, advance the model, compare at the next falling edge
  task automatic cyc();
    for (int i = 0; i < N; i++) begin
      wr_en[i] = d_wr[i];
      rel[i]   = d_rel[i];
      wr_ld[i] = d_ld[i];
      wr_st[i] = d_st[i];
      wr_addr[i*AW +: AW] = d_addr[i];
      wr_mask[i*MW +: MW] = d_mask[i];
      wr_age[i*GW +: GW]  = d_age[i][GW-1:0];
      if (d_wr[i]) begin
        m_v[i] = 1; m_addr[i] = d_addr[i]; m_mask[i] = d_mask[i];
        m_ld[i] = d_ld[i]; m_st[i] = d_st[i]; m_age[i] = d_age[i] % 8;
      end else if (d_rel[i]) begin
        m_v[i] = 0;
      end
    end
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        check("R4", $sformatf("clash[%0d][%0d]", i, j), clash_mtx[i*N+j], m_clash(i, j));
      end
      check("R9", $sformatf("issue_ok[%0d]", i), issue_ok[i], m_issue(i));
    end
    clear_drive();
  endtask

  function automatic bit [15:0] pick_mask(int k);
    case (k % 8)
      0: return 16'h0001;
      1: return 16'h0003;
      2: return 16'h000F;
      3: return 16'h00FF;
      4: return 16'hFF00;
      5: return 16'hF000;
      6: return 16'h0180;
      default: return 16'h8000;
    endcase
  endfunction

  initial begin
    int cyc_cnt = 0;
    while (!done) begin
      @(posedge clk);
      cyc_cnt++;
      if (cyc_cnt > 150000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc_cnt);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 0;
    for (int i = 0; i < N; i++) begin
      d_addr[i] = 0; d_mask[i] = 0; d_ld[i] = 0; d_st[i] = 0; d_age[i] = 0;
      m_v[i] = 0; m_addr[i] = 0; m_mask[i] = 0; m_ld[i] = 0; m_st[i] = 0; m_age[i] = 0;
    end
    clear_drive();
    wr_en = '0; rel = '0; wr_ld = '0; wr_st = '0;
    wr_addr = '0; wr_mask = '0; wr_age = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1", "clash_mtx after reset", int'(clash_mtx != '0), 0);
    check("R1", "issue_ok after reset", int'(issue_ok), 0);

    // R3/R4: store vs load, same slice, other bits differ, disjoint bytes
    put(0, 16'h0120, 16'h000F, 0, 1, 0);
    put(1, 16'h1125, 16'h0030, 1, 0, 1);
    cyc();
    check("R2", "slot0/1 issue after write", int'(issue_ok[1:0]), 3);
    check("R4", "disjoint bytes no clash", clash_mtx[0*N+1], 0);

    // R4/R3: overlapping byte, upper bit 12 differs, still clashes
    put(1, 16'h1125, 16'h0008, 1, 0, 1);
    cyc();
    check("R3", "bits above 11 ignored -> clash", clash_mtx[0*N+1], 1);
    check("R8", "mirrored bit", clash_mtx[1*N+0], 1);
    check("R9", "younger blocked", issue_ok[1], 0);
    check("R9", "older still clear", issue_ok[0], 1);

    // R3: slice differs -> no clash
    put(1, 16'h0130, 16'h0008, 1, 0, 1);
    cyc();
    check("R3", "slice mismatch no clash", clash_mtx[0*N+1], 0);

    // R5: two loads overlapping
    put(0, 16'h0200, 16'h00FF, 1, 0, 0);
    put(1, 16'h0200, 16'h00FF, 1, 0, 1);
    cyc();
    check("R5", "load/load never clash", clash_mtx[0*N+1], 0);

    // R6: atomic vs load with disjoint masks
    put(0, 16'h0200, 16'h0001, 1, 1, 0);
    put(1, 16'h0200, 16'h8000, 1, 0, 1);
    cyc();
    check("R6", "atomic clashes regardless of mask", clash_mtx[0*N+1], 1);

    // R9: age tie -> lower slot is older
    put(0, 16'h0300, 16'h0001, 0, 1, 2);
    put(1, 16'h0300, 16'h0001, 0, 1, 2);
    cyc();
    check("R9", "tie: slot0 clear", issue_ok[0], 1);
    check("R9", "tie: slot1 blocked", issue_ok[1], 0);

    // R2: release plus write in same cycle, write wins
    d_rel[1] = 1;
    put(1, 16'h0300, 16'h0002, 0, 1, 1);
    cyc();
    check("R2", "write beats release", issue_ok[1], 1);

    // R2/R7: release slot0 -> its row and column empty
    d_rel[0] = 1;
    put(2, 16'h0300, 16'h0002, 0, 1, 3);
    cyc();
    check("R7", "released slot row zero", int'(clash_mtx[0*N +: N]), 0);
    check("R2", "released slot not clear", issue_ok[0], 0);
    check("R4", "store/store overlap", clash_mtx[1*N+2], 1);

    // Random traffic compared with the model every cycle
    for (int t = 0; t < 3000; t++) begin
      for (int i = 0; i < N; i++) begin
        int r;
        r = int'($urandom_range(0, 9));
        if (r < 3) begin
          put(i, {4'($urandom), 6'h0, 2'($urandom), 4'($urandom)},
              pick_mask(int'($urandom)), 1'($urandom), 1'($urandom),
              int'($urandom_range(0, 7)));
        end
        if (r >= 2 && r < 4) d_rel[i] = 1;
      end
      cyc();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule